// File: doc/BRIEF.md
# Region Cache-Mode Demotion Controller

This block holds a cache policy for each of sixteen address regions and answers, in the same cycle, which policy covers any address presented to it. The region is taken from the top four address bits. A lookup never waits: the answer comes straight from the stored table through a multiplexer.

Software or a control agent may lower the policy of one region at a time. A request names a region through a select code and carries the new policy. The select code maps to regions in reverse order. The block accepts the request only if the new policy is strictly below the current one, in the order write-back, then write-through, then non-cacheable. It does not write an accepted change at once. It first raises a whole-cache clear request toward the cache maintenance engine, holds it until that engine reports completion, and only then writes the new policy. Every request ends in a one-cycle done pulse that carries a pass or fail bit. Policies never rise again until reset.

Top module: `region_mode_ctrl`

## Requirements
- R1: While rst_n is low on a clock edge, every region returns to write-back (3), and busy, clr_req and done go to 0.
- R2: lk_mode equals the stored policy of region lk_addr[31:28], combinationally, in the same cycle.
- R3: Select code s addresses region 15-s. Code 0 is region 15 and code 15 is region 0.
- R4: Policy codes are 0 for non-cacheable, 2 for write-through and 3 for write-back. Code 1 is reserved, and a request carrying it fails.
- R5: A request whose new policy is not strictly below the region's current one fails. In the next cycle done is 1 and pass is 0, no clear is requested, and the policy is unchanged.
- R6: An accepted request raises clr_req in the next cycle and holds it until clr_done is sampled high. Until then the region's policy is unchanged.
- R7: When clr_done is sampled high while clr_req is set, the new policy is written. In the next cycle done is 1, pass is 1, and clr_req and busy are 0.
- R8: busy is 1 for as long as a clear is pending. A request presented while busy is ignored: it produces no done and changes no region.
- R9: A policy never rises except through reset. After a region reaches non-cacheable, every further request to that region fails.
- R10: done lasts one cycle per request, and pass is 1 only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Demote request strobe |
| req_sel | input | 4 | Region select code (region = 15 - code) |
| req_mode | input | 2 | Requested policy (0 NC, 2 WT, 3 WB, 1 reserved) |
| busy | output | 1 | Clear pending; new requests are ignored |
| clr_req | output | 1 | Whole-cache clear request to the maintenance engine |
| clr_done | input | 1 | Maintenance engine reports the clear is complete |
| lk_addr | input | 32 | Lookup address |
| lk_mode | output | 2 | Policy of the region that covers lk_addr |
| done | output | 1 | One-cycle completion pulse for a request |
| pass | output | 1 | Request outcome, valid with done |

## Verification
The checker runs on every cycle and confirms the following:
- No region's policy ever rises.
- No region ever holds the reserved code.
- The table changes only on an edge where clr_req and clr_done are both high.
- A pending clear stays asserted until it is acknowledged.
- A passing done always follows a clear.
- pass never appears without done.

Other behaviours need the bench's scenarios to show them: the reversed select mapping, lookups with the right address bits, rejection by comparison against the current policy, a request ignored while busy, and the restore on reset. The bench compares each of these against a reference table it keeps itself.

// File: rtl/rmc_pkg.sv
// Shared policy encodings and helpers for the region policy controller.
// Assumes a 2-bit policy code whose numeric order matches policy strength.
package rmc_pkg;
    localparam logic [1:0] MODE_NC   = 2'd0;
    localparam logic [1:0] MODE_RSVD = 2'd1;
    localparam logic [1:0] MODE_WT   = 2'd2;
    localparam logic [1:0] MODE_WB   = 2'd3;
    localparam int         MODE_W    = 2;

    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_CLEAR = 1'b1} seq_state_t;
endpackage

// File: rtl/rmc_mode_table.sv
// Per-region policy storage. Each region has one register that resets to
// write-back and is written only through the single write port.
// Assumes wr_idx < NREG whenever wr_en is high.
module rmc_mode_table #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [rmc_pkg::MODE_W-1:0]     wr_mode,
    output logic [NREG*rmc_pkg::MODE_W-1:0] modes_flat
);
    import rmc_pkg::*;

    for (genvar g = 0; g < NREG; g++) begin : g_rgn
        logic [MODE_W-1:0] mode_q;
        // Hold one region's policy; reset restores write-back.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q <= MODE_WB;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mode_q <= wr_mode;
            end
        end
        assign modes_flat[g*MODE_W +: MODE_W] = mode_q;
    end
endmodule

// File: rtl/rmc_lookup.sv
// Address-to-policy lookup. The top IDX_W address bits pick the region.
// Purely combinational; assumes ADDR_W > IDX_W.
module rmc_lookup #(
    parameter int NREG   = 16,
    parameter int IDX_W  = $clog2(NREG),
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NREG*rmc_pkg::MODE_W-1:0] modes_flat,
    output logic [rmc_pkg::MODE_W-1:0]      mode
);
    import rmc_pkg::*;
    localparam int RGN_LSB = ADDR_W - IDX_W;

    logic [IDX_W-1:0] rgn;

    // Select the region field and return its stored policy.
    always_comb begin
        rgn  = addr[RGN_LSB +: IDX_W];
        mode = modes_flat[rgn*MODE_W +: MODE_W];
    end
endmodule

// File: rtl/rmc_demote_seq.sv
// Demotion sequencer. It judges each request against the region's current
// policy, rejects reserved or non-lowering codes at once, and runs a
// whole-cache clear handshake before committing an accepted change.
// Assumes the maintenance engine raises clr_done only while clr_req is high.
module rmc_demote_seq #(
    parameter int NREG  = 16,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [IDX_W-1:0]                req_sel,
    input  logic [rmc_pkg::MODE_W-1:0]      req_mode,
    input  logic [NREG*rmc_pkg::MODE_W-1:0] cur_modes,
    input  logic                            clr_done,
    output logic                            clr_req,
    output logic                            busy,
    output logic                            done,
    output logic                            pass,
    output logic                            wr_en,
    output logic [IDX_W-1:0]                wr_idx,
    output logic [rmc_pkg::MODE_W-1:0]      wr_mode
);
    import rmc_pkg::*;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

    seq_state_t        state_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic [MODE_W-1:0] pend_mode_q;
    logic [IDX_W-1:0]  tgt_idx;
    logic [MODE_W-1:0] tgt_cur;
    logic              legal;

    // Map the reversed select code to a region and judge the request.
    always_comb begin
        tgt_idx = TOP_IDX - req_sel;
        tgt_cur = cur_modes[tgt_idx*MODE_W +: MODE_W];
        legal   = (req_mode != MODE_RSVD) && (req_mode < tgt_cur);
    end

    // Step the accept/clear/commit sequence and form the status pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            pend_idx_q  <= '0;
            pend_mode_q <= MODE_WB;
            done        <= 1'b0;
            pass        <= 1'b0;
        end else begin
            done <= 1'b0;
            pass <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        if (legal) begin
                            state_q     <= SEQ_CLEAR;
                            pend_idx_q  <= tgt_idx;
                            pend_mode_q <= req_mode;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                SEQ_CLEAR: begin
                    if (clr_done) begin
                        state_q <= SEQ_IDLE;
                        done    <= 1'b1;
                        pass    <= 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Drive the handshake and the commit port from the pending state.
    always_comb begin
        clr_req = (state_q == SEQ_CLEAR);
        busy    = clr_req;
        wr_en   = clr_req && clr_done;
        wr_idx  = pend_idx_q;
        wr_mode = pend_mode_q;
    end
endmodule

// File: rtl/region_mode_ctrl.sv
// Top of the region policy controller: storage table, address lookup and
// demotion sequencer. Assumes one request at a time; requests while busy
// are dropped.
module region_mode_ctrl #(
    parameter int NREG   = 16,
    parameter int IDX_W  = $clog2(NREG),
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_sel,
    input  logic [1:0]        req_mode,
    output logic              busy,
    output logic              clr_req,
    input  logic              clr_done,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [1:0]        lk_mode,
    output logic              done,
    output logic              pass
);
    import rmc_pkg::*;

    logic [NREG*MODE_W-1:0] modes_flat;
    logic                   wr_en;
    logic [IDX_W-1:0]       wr_idx;
    logic [MODE_W-1:0]      wr_mode;

    rmc_mode_table #(.NREG(NREG), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_mode(wr_mode), .modes_flat(modes_flat)
    );

    rmc_lookup #(.NREG(NREG), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_lookup (
        .addr(lk_addr), .modes_flat(modes_flat), .mode(lk_mode)
    );

    rmc_demote_seq #(.NREG(NREG), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_mode(req_mode), .cur_modes(modes_flat), .clr_done(clr_done),
        .clr_req(clr_req), .busy(busy), .done(done), .pass(pass),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode)
    );
endmodule

// File: rtl/rmc_checker.sv
// Protocol and invariant checks for region_mode_ctrl, attached by bind.
module rmc_checker #(
    parameter int NREG = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NREG*2-1:0]     modes_flat,
    input logic                  clr_req,
    input logic                  clr_done,
    input logic                  done,
    input logic                  pass
);
    for (genvar g = 0; g < NREG; g++) begin : g_chk
        AST_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
            modes_flat[g*2 +: 2] <= $past(modes_flat[g*2 +: 2])); // R9
        AST_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
            modes_flat[g*2 +: 2] != 2'd1); // R4
    end

    AST_WRITE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (modes_flat != $past(modes_flat)) |-> $past(clr_req && clr_done)); // R6
    AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !clr_done) |=> clr_req); // R6
    AST_PASS_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> $past(clr_req && clr_done)); // R7
    AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done); // R10
endmodule

bind region_mode_ctrl rmc_checker #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .modes_flat(modes_flat), .clr_req(clr_req),
    .clr_done(clr_done), .done(done), .pass(pass)
);

// File: tb/tb_region_mode_ctrl.sv
`timescale 1ns/1ps
module tb_region_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_sel = '0;
    logic [1:0]  req_mode = '0;
    logic        busy, clr_req, done, pass;
    logic        clr_done = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_mode;

    int n_chk = 0;
    int n_err = 0;
    logic [1:0] exp_mode [16];

    always #2.5 clk = ~clk;

    region_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_mode(req_mode), .busy(busy), .clr_req(clr_req), .clr_done(clr_done),
        .lk_addr(lk_addr), .lk_mode(lk_mode), .done(done), .pass(pass)
    );

    function automatic bit exp_legal(logic [1:0] cur, logic [1:0] nm);
        return (nm != 2'd1) && (nm < cur);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic look(input logic [3:0] r, input string tag);
        lk_addr = {r, 28'($urandom)};
        #0.5;
        check(lk_mode == exp_mode[r], tag, lk_mode, exp_mode[r]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 16; i++) exp_mode[i] = 2'd3;
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(clr_req == 1'b0, "R1 clr_req", clr_req, 0);
        check(done == 1'b0, "R1 done", done, 0);
        for (int i = 0; i < 16; i++) look(4'(i), "R1 reset mode");
    endtask

    task automatic demote(input logic [3:0] sel, input logic [1:0] m,
                          input int wait_cyc, input bit poke);
        logic [3:0] rgn;
        logic [3:0] prgn;
        bit         ok;
        rgn  = 4'd15 - sel;
        prgn = 4'd15 - (sel ^ 4'h1);
        ok   = exp_legal(exp_mode[rgn], m);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (!ok) begin
            check(done == 1'b1, "R5 done", done, 1);
            check(pass == 1'b0, "R5 pass", pass, 0);
            check(clr_req == 1'b0, "R5 no clear", clr_req, 0);
            look(rgn, "R5 unchanged");
            @(negedge clk);
            check(done == 1'b0, "R10 single pulse", done, 0);
        end else begin
            check(clr_req == 1'b1, "R6 clr_req", clr_req, 1);
            check(busy == 1'b1, "R8 busy", busy, 1);
            check(done == 1'b0, "R6 no early done", done, 0);
            for (int i = 0; i < wait_cyc; i++) begin
                if (poke && i == 0) begin
                    req_valid = 1'b1; req_sel = sel ^ 4'h1; req_mode = 2'd0;
                end
                @(negedge clk);
                req_valid = 1'b0;
                check(clr_req == 1'b1, "R6 held", clr_req, 1);
                check(done == 1'b0, "R8 ignored no done", done, 0);
                look(rgn, "R6 unchanged while pending");
            end
            clr_done = 1'b1;
            @(negedge clk);
            clr_done = 1'b0;
            exp_mode[rgn] = m;
            check(done == 1'b1, "R7 done", done, 1);
            check(pass == 1'b1, "R7 pass", pass, 1);
            check(clr_req == 1'b0, "R7 clr drop", clr_req, 0);
            check(busy == 1'b0, "R8 busy drop", busy, 0);
            look(rgn, "R7 written");
            if (poke) look(prgn, "R8 poked region");
            @(negedge clk);
            check(done == 1'b0, "R10 single pulse", done, 0);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        do_reset();
        // R3: code 0 hits region 15, region 0 untouched
        demote(4'd0, 2'd2, 2, 1'b0);
        look(4'd15, "R3 code0 region15");
        look(4'd0, "R3 region0 untouched");
        // R3: code 15 hits region 0
        demote(4'd15, 2'd0, 0, 1'b0);
        look(4'd0, "R3 code15 region0");
        // R4: reserved code
        demote(4'd5, 2'd1, 0, 1'b0);
        // R5: equal and higher
        demote(4'd5, 2'd3, 0, 1'b0);
        demote(4'd0, 2'd3, 0, 1'b0);
        demote(4'd0, 2'd2, 0, 1'b0);
        // R8: ignored request while busy
        demote(4'd6, 2'd2, 3, 1'b1);
        // R9: NC region refuses everything
        demote(4'd15, 2'd0, 0, 1'b0);
        demote(4'd15, 2'd2, 0, 1'b0);
        // random mix
        for (int k = 0; k < 250; k++) begin
            demote(4'($urandom % 16), 2'($urandom % 4), int'($urandom % 5),
                   1'($urandom % 2));
            look(4'($urandom % 16), "R2 random lookup");
        end
        // R9: only reset restores write-back
        do_reset();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule